// File: doc/BRIEF.md
# Wear-Aware Read Retry Sequencer

This block steers a single page read through a series of sense and decode attempts. When a read request arrives, it takes the block's program/erase count and sorts it into a wear bin. From that bin it picks a starting sensing precision for the front end. The precision is a pair (m+n): m is the bits per cell sensed on the wordline being read, and n is the bits per cell sensed on the neighbouring interfering wordline. Each sense is followed by a decode. On a failure, the sequencer raises the precision and senses again.

In the default hierarchical mode, the cheap on-die hard-input decoder is tried at each precision. Only after it has failed at the finest precision (5+4) are those same sensed samples handed to the full-strength soft decoder. A second mode models a controller that has only the strong decoder. That mode uses its own, lower start table and escalates on strong failures. The sequencer adds up a modelled sensing latency for every sense it issues. It reports the final precision, the number of decode attempts and whether the page was uncorrectable.

Top module: `read_retry_seq`

## Requirements
- R1: After reset, `busy`, `sense_go`, `dec_go`, `done` and `uncorrectable` are all low.
- R2: Wear bins are 2000 cycles wide (bin = pe_count/2000), and any count of 10000 or more falls into the last bin (bin 4).
- R3: With `strong_only`=0, the starting (m+n) for bins 0..4 is (3+2), (4+1), (4+1), (4+1), (4+2).
- R4: With `strong_only`=1, the starting (m+n) for bins 0..4 is (3+1), (3+2), (3+2), (4+1), (4+1).
- R5: After a failed attempt that may escalate, the next sense raises m by one if m<5. Otherwise it raises n by one, up to 4. The commanded m never exceeds 5 and n never exceeds 4.
- R6: With `strong_only`=0, every decode uses the weak decoder (`dec_strong`=0). Once the weak decode at (5+4) fails, exactly one strong decode (`dec_strong`=1) is issued with no new sense.
- R7: A decode counts as passed only when `dec_ok`=1 and `dec_iters` is 8 or less. A count of 9 or more is a failure even if `dec_ok` is high.
- R8: A strong-decoder failure at (5+4) ends the read with `done` and `uncorrectable` high in the same cycle. With `strong_only`=1, strong failures below (5+4) escalate as in R5.
- R9: `latency_tenths` is cleared when a request is accepted. Every completed sense adds lat(m)+lat(n), where lat(k)=(600*(2^k-1)+3)/7 in tenths of a microsecond (86, 257, 600, 1286, 2657 for k=1..5).
- R10: `attempts` counts the decodes of the current read. `done` is a one-cycle pulse with `busy` low. `final_m`/`final_n` hold the last sensed precision. A request raised while busy is ignored. Accepting a request raises `busy` and `sense_go` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a page read (taken only when idle) |
| strong_only | input | 1 | 1: strong decoder only; 0: weak-then-strong hierarchy |
| pe_count | input | 16 | Program/erase count of the block being read |
| sense_ready | input | 1 | Front end finished the commanded sense |
| dec_done | input | 1 | Decoder finished an attempt |
| dec_ok | input | 1 | Decoder reports convergence |
| dec_iters | input | 4 | Iterations the decoder used |
| busy | output | 1 | A read is in progress |
| sense_go | output | 1 | One-cycle sense command |
| sense_m | output | 3 | Bits per cell on the read wordline |
| sense_n | output | 3 | Bits per cell on the interfering wordline |
| dec_go | output | 1 | One-cycle decode command |
| dec_strong | output | 1 | Selects the strong decoder for this attempt |
| done | output | 1 | One-cycle end-of-read pulse |
| uncorrectable | output | 1 | With done: the page could not be recovered |
| final_m | output | 3 | Last sensed m |
| final_n | output | 3 | Last sensed n |
| attempts | output | 4 | Decodes issued in the current read |
| latency_tenths | output | 20 | Accumulated sensing latency, 0.1 us units |

## Verification
Reads are run in both modes across wear counts at, just below and far above the bin edges. Each read gets a scripted list of decode outcomes, so the bench can compare first-try success, mid-ladder success, a weak-path failure rescued by the strong decoder, and an all-fail uncorrectable ending. One outcome converges with `dec_ok` high but after nine iterations, which separates the iteration cap from the ok flag alone. A reference model in the bench predicts every commanded (m+n), the decoder choice, the latency sum and the attempt count, and it compares them as each command appears. A stray request during a read shows whether it leaks into the result.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int M_MAX = 5;
    localparam int N_MAX = 4;

    typedef struct packed {
        logic [2:0] m;
        logic [2:0] n;
    } prec_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SENSE  = 2'd1,
        ST_DECODE = 2'd2
    } state_t;

    // Starting precision by wear bin; strong_first selects the table for a
    // read whose first decoder is the full-strength one.
    function automatic prec_t start_prec(input logic strong_first, input logic [2:0] bin);
        prec_t p;
        if (strong_first) begin
            case (bin)
                3'd0:          p = '{m: 3'd3, n: 3'd1};
                3'd1, 3'd2:    p = '{m: 3'd3, n: 3'd2};
                default:       p = '{m: 3'd4, n: 3'd1};
            endcase
        end else begin
            case (bin)
                3'd0:               p = '{m: 3'd3, n: 3'd2};
                3'd1, 3'd2, 3'd3:   p = '{m: 3'd4, n: 3'd1};
                default:            p = '{m: 3'd4, n: 3'd2};
            endcase
        end
        return p;
    endfunction

    // Modelled sense time for k bits, tenths of a microsecond: (600*(2^k-1)+3)/7
    function automatic logic [11:0] sense_lat(input logic [2:0] bits);
        int v;
        v = (600 * ((1 << bits) - 1) + 3) / 7;
        return v[11:0];
    endfunction

endpackage

// File: rtl/rrs_wear_bin.sv
module rrs_wear_bin #(
    parameter int PE_W     = 16,
    parameter int BIN_SIZE = 2000,
    parameter int NUM_BINS = 5,
    parameter int BIN_W    = 3
) (
    input  logic [PE_W-1:0]  pe_count,
    output logic [BIN_W-1:0] bin
);
    localparam int EDGES = NUM_BINS - 1;

    logic [EDGES-1:0] past_edge;

    genvar g;
    generate
        for (g = 1; g <= EDGES; g++) begin : g_edge
            assign past_edge[g-1] = (32'(pe_count) >= 32'(g * BIN_SIZE));
        end
    endgenerate

    // Saturates naturally: all edges passed gives the last bin.
    always_comb begin
        bin = '0;
        for (int i = 0; i < EDGES; i++) begin
            bin = bin + BIN_W'(past_edge[i]);
        end
    end
endmodule

// File: rtl/rrs_escalate.sv
module rrs_escalate
    import rrs_pkg::*;
(
    input  prec_t cur,
    output prec_t nxt,
    output logic  at_max
);
    always_comb begin
        nxt    = cur;
        at_max = 1'b0;
        if (32'(cur.m) < M_MAX) begin
            nxt.m = cur.m + 3'd1;
        end else if (32'(cur.n) < N_MAX) begin
            nxt.n = cur.n + 3'd1;
        end else begin
            at_max = 1'b1;
        end
    end
endmodule

// File: rtl/rrs_lat_acc.sv
module rrs_lat_acc
    import rrs_pkg::*;
#(
    parameter int LAT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add_en,
    input  prec_t            prec,
    output logic [LAT_W-1:0] acc
);
    logic [LAT_W-1:0] step;

    always_comb begin
        step = LAT_W'(sense_lat(prec.m)) + LAT_W'(sense_lat(prec.n));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= acc + step;
        end
    end
endmodule

// File: rtl/read_retry_seq.sv
module read_retry_seq
    import rrs_pkg::*;
#(
    parameter int PE_W     = 16,
    parameter int BIN_SIZE = 2000,
    parameter int NUM_BINS = 5,
    parameter int ITER_MAX = 8,
    parameter int ITER_W   = 4,
    parameter int ATT_W    = 4,
    parameter int LAT_W    = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              strong_only,
    input  logic [PE_W-1:0]   pe_count,
    input  logic              sense_ready,
    input  logic              dec_done,
    input  logic              dec_ok,
    input  logic [ITER_W-1:0] dec_iters,
    output logic              busy,
    output logic              sense_go,
    output logic [2:0]        sense_m,
    output logic [2:0]        sense_n,
    output logic              dec_go,
    output logic              dec_strong,
    output logic              done,
    output logic              uncorrectable,
    output logic [2:0]        final_m,
    output logic [2:0]        final_n,
    output logic [ATT_W-1:0]  attempts,
    output logic [LAT_W-1:0]  latency_tenths
);
    localparam int BIN_W = 3;

    state_t           state;
    prec_t            cur;
    prec_t            nxt;
    prec_t            first;
    logic             at_max;
    logic [BIN_W-1:0] bin;
    logic             mode_strong;
    logic             stage_strong;
    logic             sense_go_q;
    logic             dec_go_q;
    logic             done_q;
    logic             unc_q;
    logic [ATT_W-1:0] att_q;
    logic             accept;
    logic             dec_pass;
    logic             may_escalate;

    rrs_wear_bin #(
        .PE_W    (PE_W),
        .BIN_SIZE(BIN_SIZE),
        .NUM_BINS(NUM_BINS),
        .BIN_W   (BIN_W)
    ) bin_i (
        .pe_count(pe_count),
        .bin     (bin)
    );

    rrs_escalate esc_i (
        .cur   (cur),
        .nxt   (nxt),
        .at_max(at_max)
    );

    rrs_lat_acc #(.LAT_W(LAT_W)) lat_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .add_en(state == ST_SENSE && sense_ready),
        .prec  (cur),
        .acc   (latency_tenths)
    );

    always_comb begin
        first        = start_prec(strong_only, bin);
        accept       = (state == ST_IDLE) && req;
        dec_pass     = dec_ok && (32'(dec_iters) <= ITER_MAX);
        may_escalate = (!stage_strong || mode_strong) && !at_max;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cur          <= '0;
            mode_strong  <= 1'b0;
            stage_strong <= 1'b0;
            sense_go_q   <= 1'b0;
            dec_go_q     <= 1'b0;
            done_q       <= 1'b0;
            unc_q        <= 1'b0;
            att_q        <= '0;
        end else begin
            sense_go_q <= 1'b0;
            dec_go_q   <= 1'b0;
            done_q     <= 1'b0;
            unc_q      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        cur          <= first;
                        mode_strong  <= strong_only;
                        stage_strong <= strong_only;
                        att_q        <= '0;
                        sense_go_q   <= 1'b1;
                        state        <= ST_SENSE;
                    end
                end
                ST_SENSE: begin
                    if (sense_ready) begin
                        dec_go_q <= 1'b1;
                        state    <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (dec_done) begin
                        att_q <= att_q + ATT_W'(1);
                        if (dec_pass) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (may_escalate) begin
                            cur        <= nxt;
                            sense_go_q <= 1'b1;
                            state      <= ST_SENSE;
                        end else if (!stage_strong) begin
                            stage_strong <= 1'b1;
                            dec_go_q     <= 1'b1;
                        end else begin
                            done_q <= 1'b1;
                            unc_q  <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state != ST_IDLE);
    assign sense_go      = sense_go_q;
    assign sense_m       = cur.m;
    assign sense_n       = cur.n;
    assign dec_go        = dec_go_q;
    assign dec_strong    = stage_strong;
    assign done          = done_q;
    assign uncorrectable = unc_q;
    assign final_m       = cur.m;
    assign final_n       = cur.n;
    assign attempts      = att_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
    input logic       clk,
    input logic       rst,
    input logic       strong_only_lat,
    input logic       busy,
    input logic       sense_go,
    input logic [2:0] sense_m,
    input logic [2:0] sense_n,
    input logic       dec_go,
    input logic       dec_strong,
    input logic       done,
    input logic       uncorrectable
);
    // R5: commanded precision stays within the (5+4) ceiling
    a_r5_prec_range: assert property (@(posedge clk) disable iff (rst)
        sense_go |-> (sense_m <= 3'd5 && sense_n <= 3'd4 && sense_m >= 3'd3));

    // R6: in hierarchical mode the strong decoder only runs at (5+4)
    a_r6_strong_at_max: assert property (@(posedge clk) disable iff (rst)
        (dec_go && dec_strong && !strong_only_lat) |-> (sense_m == 3'd5 && sense_n == 3'd4));

    // R8: uncorrectable is only reported together with done
    a_r8_unc_with_done: assert property (@(posedge clk) disable iff (rst)
        uncorrectable |-> done);

    // R10: done arrives with the sequencer back in idle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10: a read starts with a sense command
    a_r10_start_sense: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> sense_go);

    // R6: sense and decode commands never coincide
    a_r6_cmd_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sense_go && dec_go));
endmodule

bind read_retry_seq rrs_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .strong_only_lat(mode_strong),
    .busy           (busy),
    .sense_go       (sense_go),
    .sense_m        (sense_m),
    .sense_n        (sense_n),
    .dec_go         (dec_go),
    .dec_strong     (dec_strong),
    .done           (done),
    .uncorrectable  (uncorrectable)
);

// File: tb/read_retry_seq_tb_top.sv
module read_retry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        strong_only = 1'b0;
    logic [15:0] pe_count = '0;
    logic        sense_ready = 1'b0;
    logic        dec_done = 1'b0;
    logic        dec_ok = 1'b0;
    logic [3:0]  dec_iters = '0;
    logic        busy, sense_go, dec_go, dec_strong, done, uncorrectable;
    logic [2:0]  sense_m, sense_n, final_m, final_n;
    logic [3:0]  attempts;
    logic [19:0] latency_tenths;

    int checks = 0;
    int errors = 0;
    int outq[$];
    bit poke_busy = 1'b0;

    int lat_tab[6]  = '{0, 86, 257, 600, 1286, 2657};
    int weak_m[5]   = '{3, 4, 4, 4, 4};
    int weak_n[5]   = '{2, 1, 1, 1, 2};
    int str_m[5]    = '{3, 3, 3, 4, 4};
    int str_n[5]    = '{1, 2, 2, 1, 1};

    always #4 clk = ~clk;

    read_retry_seq dut_i (
        .clk(clk), .rst(rst), .req(req), .strong_only(strong_only),
        .pe_count(pe_count), .sense_ready(sense_ready), .dec_done(dec_done),
        .dec_ok(dec_ok), .dec_iters(dec_iters), .busy(busy), .sense_go(sense_go),
        .sense_m(sense_m), .sense_n(sense_n), .dec_go(dec_go),
        .dec_strong(dec_strong), .done(done), .uncorrectable(uncorrectable),
        .final_m(final_m), .final_n(final_n), .attempts(attempts),
        .latency_tenths(latency_tenths)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Returns 1 if the chosen output went high within the limit.
    task automatic wait_out(input int which, output bit seen);
        int t = 0;
        seen = 1'b0;
        while (t < 300) begin
            if ((which == 0 && sense_go) || (which == 1 && dec_go) || (which == 2 && done)) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
            t++;
        end
    endtask

    task automatic run_read(input int pe, input bit so, input string name);
        int  bin, em, en, elat, eatt, oc;
        bit  stage, need_sense, fin, exp_unc, seen, pass;
        bin  = (pe >= 10000) ? 4 : pe / 2000;
        em   = so ? str_m[bin] : weak_m[bin];
        en   = so ? str_n[bin] : weak_n[bin];
        elat = 0; eatt = 0; stage = so; need_sense = 1'b1; fin = 1'b0; exp_unc = 1'b0;

        @(negedge clk);
        req = 1'b1; strong_only = so; pe_count = 16'(pe);
        @(negedge clk);
        req = 1'b0;
        pe_count = 16'd0;
        strong_only = ~so;

        while (!fin) begin
            if (need_sense) begin
                wait_out(0, seen);
                if (!seen) begin
                    chk(1'b0, {name, " R10 sense_go missing"}, 0, 1);
                    return;
                end
                chk(int'(sense_m) == em, {name, " R3/R4/R5 sense_m"}, int'(sense_m), em);
                chk(int'(sense_n) == en, {name, " R3/R4/R5 sense_n"}, int'(sense_n), en);
                elat += lat_tab[em] + lat_tab[en];
                @(negedge clk);
                if (poke_busy) begin
                    req = 1'b1; pe_count = 16'd100; strong_only = ~so;
                end
                @(negedge clk);
                req = 1'b0;
                sense_ready = 1'b1;
                @(negedge clk);
                sense_ready = 1'b0;
            end
            wait_out(1, seen);
            if (!seen) begin
                chk(1'b0, {name, " R6 dec_go missing"}, 0, 1);
                return;
            end
            chk(dec_strong == stage, {name, " R6 dec_strong"}, int'(dec_strong), int'(stage));
            oc = (outq.size() > 0) ? outq.pop_front() : 0;
            @(negedge clk);
            dec_done  = 1'b1;
            dec_ok    = (oc != 0);
            dec_iters = (oc == 2) ? 4'd9 : (oc == 3) ? 4'd8 : (oc == 1) ? 4'd3 : 4'd8;
            @(negedge clk);
            dec_done = 1'b0; dec_ok = 1'b0; dec_iters = '0;
            eatt++;
            pass = (oc == 1 || oc == 3);
            if (pass) begin
                fin = 1'b1;
            end else if ((!stage || so) && !(em == 5 && en == 4)) begin
                if (em < 5) em++; else en++;
                need_sense = 1'b1;
            end else if (!stage) begin
                stage = 1'b1;
                need_sense = 1'b0;
            end else begin
                exp_unc = 1'b1;
                fin = 1'b1;
            end
        end

        wait_out(2, seen);
        chk(seen, {name, " R10 done pulse"}, int'(seen), 1);
        chk(uncorrectable == exp_unc, {name, " R8 uncorrectable"}, int'(uncorrectable), int'(exp_unc));
        chk(!busy, {name, " R10 idle at done"}, int'(busy), 0);
        chk(int'(final_m) == em && int'(final_n) == en, {name, " R10 final precision"},
            int'(final_m) * 10 + int'(final_n), em * 10 + en);
        chk(int'(attempts) == eatt, {name, " R10 attempts"}, int'(attempts), eatt);
        chk(int'(latency_tenths) == elat, {name, " R9 latency"}, int'(latency_tenths), elat);
        @(negedge clk);
        chk(!done, {name, " R10 done one cycle"}, int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !sense_go && !dec_go && !done && !uncorrectable, "R1 reset state",
            int'({busy, sense_go, dec_go, done, uncorrectable}), 0);

        // R3 bin 0 first-try pass
        outq = '{1};
        run_read(0, 1'b0, "weak bin0");
        // R3 R5 R7 bin 1, two failures then pass; stray request while busy (R10)
        poke_busy = 1'b1;
        outq = '{0, 2, 1};
        run_read(2500, 1'b0, "weak bin1 retry");
        poke_busy = 1'b0;
        // R6 R8 bin 4 all fail -> uncorrectable
        outq = '{0, 0, 0, 0, 0};
        run_read(9999, 1'b0, "weak all fail");
        // R2 saturation, R6 strong rescue
        outq = '{0, 0, 0, 0, 1};
        run_read(65000, 1'b0, "weak saturated rescue");
        // R2 bin edges
        outq = '{1};
        run_read(1999, 1'b0, "weak edge 1999");
        outq = '{1};
        run_read(2000, 1'b0, "weak edge 2000");
        outq = '{1};
        run_read(8000, 1'b0, "weak bin4");
        // R4 R7 strong-only: converged after 9 iterations fails, then 8 passes
        outq = '{2, 3};
        run_read(0, 1'b1, "strong bin0 cap");
        // R4 R8 strong-only escalation to uncorrectable
        outq = '{0, 0, 0, 0, 0};
        run_read(6000, 1'b1, "strong bin3 fail");
        outq = '{1};
        run_read(4000, 1'b1, "strong bin2");
        outq = '{0, 1};
        run_read(12000, 1'b1, "strong saturated");

        finish_run();
    end

endmodule